// File: doc/BRIEF.md
# Dual-Port Handshake Parallel I/O Controller

This block drives two 8-bit peripheral data ports, A and B. Each port has a ready output and an active-low strobe input. Software chooses an operating mode for each port. Mode 0 is handshaked output, mode 1 is handshaked input and mode 3 is control mode, with no handshake. Port A has one more choice, mode 2, a bidirectional transfer. In mode 2, port A's own strobe and ready lines carry the outgoing direction. The incoming direction uses port B's strobe and ready lines.

The CPU reaches the block through a plain synchronous register interface. One bit selects the port. A second bit chooses between that port's control word and its data register. There are separate read and write strobes. A handshake completes when the peripheral strobe rises. If the interrupt enable of the owning port is set, that completion latches an interrupt request. Any data access to that port, or a control write to it, clears the request. The incoming direction of mode 2 belongs to port B's enable.

Strobes go through a two-stage synchronizer before edge detection. Input data is captured on the raw strobe level, so the peripheral may withdraw data as soon as the strobe rises.

Top module: `pio_dual_hs`

## Requirements
- R1: After reset both ports are in mode 1 with the interrupt enable clear. Each control word reads back as 8'h01. Both ready outputs, both output enables and irq are low.
- R2: A control write sets the mode from wdata[1:0] (0 output, 1 input, 2 bidirectional, 3 control) and the interrupt enable from wdata[7]. A control read returns {ie, 5'b0, mode}. Writing mode 2 to port B leaves port B's mode unchanged.
- R3: In mode 0 a data write appears on the port's output pins with the output enable high, and ready is high from the next clock. A low strobe clears ready.
- R4: The rising edge of a port's strobe in mode 0 or 1 raises irq only when that port's enable is set. The request holds until a data access to that port clears it.
- R5: In mode 1 the output enable is low and a data read raises ready. A low strobe captures the pins and clears ready. The captured value survives the pins changing in the same cycle as the strobe rises.
- R6: In mode 2, port A's output enable is high only while a_stb_n is low. A data write to port A raises a_rdy, a_stb_n low clears it, and its rising edge raises irq through port A's enable.
- R7: In mode 2, b_stb_n low captures a_in into port A's read data. A port A data read raises b_rdy, and b_stb_n low clears it. The rising edge of b_stb_n raises irq only when port B's enable is set, and a port A data read clears that request.
- R8: In mode 3, a_rdy stays low and the output enable is high. A data write appears on the pins from the next clock, and a data read returns the live input pins.
- R9: While port B is in mode 3, b_rdy is low unless port A is in mode 2. In that case b_rdy follows port A's input handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_sel | input | 1 | Port select: 0 for A, 1 for B |
| cpu_ctl | input | 1 | 1 selects the control word, 0 the data register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| a_in | input | 8 | Port A pins, inbound |
| a_out | output | 8 | Port A pins, outbound |
| a_oe | output | 1 | Port A output enable |
| a_stb_n | input | 1 | Port A strobe, active low |
| a_rdy | output | 1 | Port A ready |
| b_in | input | 8 | Port B pins, inbound |
| b_out | output | 8 | Port B pins, outbound |
| b_oe | output | 1 | Port B output enable |
| b_stb_n | input | 1 | Port B strobe, active low |
| b_rdy | output | 1 | Port B ready |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench targets the zero-hold capture. It changes the pins in the same cycle that the strobe rises. A design that captured on the synchronized strobe would then latch the new value instead of the strobed one.

It checks the line borrowing of mode 2 in three ways:
- It checks that b_rdy follows port A's input handshake while port B sits in control mode. A design that ignored the borrow would leave b_rdy low.
- It checks that the input-side interrupt follows port B's enable, not port A's.
- It checks that the output enable drops as soon as a_stb_n goes high. A latched enable would drive against the peripheral.

It also checks that a mode 2 request to port B is refused, and that ready is forced low in control mode.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {
      PM_OUT   = 2'd0,
      PM_IN    = 2'd1,
      PM_BIDIR = 2'd2,
      PM_CTRL  = 2'd3
   } pio_mode_e;

   localparam int MODE_W = 2;
endpackage

// File: rtl/pio_stb_sync.sv
module pio_stb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_n,
   output logic lvl_n,
   output logic fall,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pio_stb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], stb_n};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_n = chain_q[STAGES-1];
   assign fall  = last_q & ~lvl_n;
   assign rise  = ~last_q & lvl_n;
endmodule

// File: rtl/pio_hs_engine.sv
module pio_hs_engine (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic arm,
   input  logic fall,
   input  logic rise,
   output logic rdy,
   output logic done
);
   always_ff @(posedge clk) begin
      if (!rst_n)       rdy <= 1'b0;
      else if (!active) rdy <= 1'b0;
      else if (arm)     rdy <= 1'b1;
      else if (fall)    rdy <= 1'b0;
   end

   assign done = active & rise;

   // R3
   arm_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && arm) |=> rdy);

   // R3
   stb_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !arm) |=> !rdy);
endmodule

// File: rtl/pio_port.sv
module pio_port
   import pio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit BIDIR_OK    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lend,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_out,
   output logic              pin_oe,
   input  logic              stb_n,
   output logic              own_rdy,
   output logic              own_done,
   input  logic              aux_stb_n,
   output logic              aux_rdy,
   output logic              aux_done,
   output pio_mode_e         mode,
   output logic              ie,
   output logic [DATA_W-1:0] rd_val
);
   localparam int IE_BIT = DATA_W - 1;

   generate
      if (DATA_W < MODE_W + 1) begin : g_bad_width
         $error("pio_port: DATA_W too small for the control word");
      end
   endgenerate

   logic [DATA_W-1:0] out_q, cap_q;
   pio_mode_e         req_mode;
   logic              own_lvl_n, own_fall, own_rise;
   logic              own_active, own_arm;

   assign req_mode = pio_mode_e'(wdata[MODE_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= PM_IN;
         ie   <= 1'b0;
      end else if (cfg_wr) begin
         ie <= wdata[IE_BIT];
         if (BIDIR_OK || req_mode != PM_BIDIR) mode <= req_mode;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       out_q <= '0;
      else if (data_wr) out_q <= wdata;
   end

   // capture on the raw strobe level: the last edge with strobe low wins
   always_ff @(posedge clk) begin
      if (!rst_n)
         cap_q <= '0;
      else if (mode == PM_IN && !lend && !stb_n)
         cap_q <= pin_in;
      else if (BIDIR_OK && mode == PM_BIDIR && !aux_stb_n)
         cap_q <= pin_in;
   end

   pio_stb_sync #(.STAGES(SYNC_STAGES)) u_own_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .stb_n (stb_n),
      .lvl_n (own_lvl_n),
      .fall  (own_fall),
      .rise  (own_rise)
   );

   assign own_active = (mode != PM_CTRL) && !lend && !cfg_wr;
   assign own_arm    = (mode == PM_IN) ? data_rd : data_wr;

   pio_hs_engine u_own_hs (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (own_active),
      .arm    (own_arm),
      .fall   (own_fall),
      .rise   (own_rise),
      .rdy    (own_rdy),
      .done   (own_done)
   );

   generate
      if (BIDIR_OK) begin : g_aux
         logic aux_lvl_n, aux_fall, aux_rise, aux_active;
         pio_stb_sync #(.STAGES(SYNC_STAGES)) u_aux_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .stb_n (aux_stb_n),
            .lvl_n (aux_lvl_n),
            .fall  (aux_fall),
            .rise  (aux_rise)
         );
         assign aux_active = (mode == PM_BIDIR) && !cfg_wr;
         pio_hs_engine u_aux_hs (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (aux_active),
            .arm    (data_rd),
            .fall   (aux_fall),
            .rise   (aux_rise),
            .rdy    (aux_rdy),
            .done   (aux_done)
         );
      end else begin : g_no_aux
         logic unused_aux;
         assign unused_aux = aux_stb_n;
         assign aux_rdy    = 1'b0;
         assign aux_done   = 1'b0;

         // R2
         no_bidir_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode != PM_BIDIR);
      end
   endgenerate

   always_comb begin
      unique case (mode)
         PM_OUT:   pin_oe = 1'b1;
         PM_IN:    pin_oe = 1'b0;
         PM_BIDIR: pin_oe = ~stb_n;
         default:  pin_oe = 1'b1;
      endcase
   end

   always_comb begin
      unique case (mode)
         PM_OUT:           rd_val = out_q;
         PM_IN, PM_BIDIR:  rd_val = cap_q;
         default:          rd_val = pin_in;
      endcase
   end

   assign pin_out = out_q;

   // R6
   bidir_oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_BIDIR && stb_n) |-> !pin_oe);

   // R5
   input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_IN) |-> !pin_oe);
endmodule

// File: rtl/pio_dual_hs.sv
module pio_dual_hs
   import pio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic              cpu_sel,
   input  logic              cpu_ctl,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic              a_oe,
   input  logic              a_stb_n,
   output logic              a_rdy,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic              b_oe,
   input  logic              b_stb_n,
   output logic              b_rdy,
   output logic              irq
);
   localparam int PAD_W = DATA_W - MODE_W - 1;

   logic a_cfg_wr, a_data_wr, a_data_rd, b_cfg_wr, b_data_wr, b_data_rd;
   logic a_own_rdy, a_own_done, a_aux_rdy, a_aux_done, a_ie;
   logic b_own_rdy, b_own_done, b_aux_rdy, b_aux_done, b_ie;
   logic a_bidir, pend_a, pend_b;
   pio_mode_e a_mode, b_mode;
   logic [DATA_W-1:0] a_rd, b_rd, cfg_view;

   assign a_cfg_wr  = cpu_wr &  cpu_ctl & ~cpu_sel;
   assign a_data_wr = cpu_wr & ~cpu_ctl & ~cpu_sel;
   assign a_data_rd = cpu_rd & ~cpu_ctl & ~cpu_sel;
   assign b_cfg_wr  = cpu_wr &  cpu_ctl &  cpu_sel;
   assign b_data_wr = cpu_wr & ~cpu_ctl &  cpu_sel;
   assign b_data_rd = cpu_rd & ~cpu_ctl &  cpu_sel;
   assign a_bidir   = (a_mode == PM_BIDIR);

   pio_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .BIDIR_OK(1'b1)) u_port_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (a_cfg_wr),
      .data_wr   (a_data_wr),
      .data_rd   (a_data_rd),
      .wdata     (cpu_wdata),
      .lend      (1'b0),
      .pin_in    (a_in),
      .pin_out   (a_out),
      .pin_oe    (a_oe),
      .stb_n     (a_stb_n),
      .own_rdy   (a_own_rdy),
      .own_done  (a_own_done),
      .aux_stb_n (b_stb_n),
      .aux_rdy   (a_aux_rdy),
      .aux_done  (a_aux_done),
      .mode      (a_mode),
      .ie        (a_ie),
      .rd_val    (a_rd)
   );

   pio_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .BIDIR_OK(1'b0)) u_port_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (b_cfg_wr),
      .data_wr   (b_data_wr),
      .data_rd   (b_data_rd),
      .wdata     (cpu_wdata),
      .lend      (a_bidir),
      .pin_in    (b_in),
      .pin_out   (b_out),
      .pin_oe    (b_oe),
      .stb_n     (b_stb_n),
      .own_rdy   (b_own_rdy),
      .own_done  (b_own_done),
      .aux_stb_n (1'b1),
      .aux_rdy   (b_aux_rdy),
      .aux_done  (b_aux_done),
      .mode      (b_mode),
      .ie        (b_ie),
      .rd_val    (b_rd)
   );

   // port B's ready line belongs to port A's input direction in mode 2
   assign a_rdy = a_own_rdy;
   assign b_rdy = a_bidir ? a_aux_rdy : (b_own_rdy | b_aux_rdy);

   always_ff @(posedge clk) begin
      if (!rst_n)                              pend_a <= 1'b0;
      else if (a_own_done && a_ie)             pend_a <= 1'b1;
      else if (a_data_wr || a_data_rd || a_cfg_wr) pend_a <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_b <= 1'b0;
      else if ((b_own_done || b_aux_done || a_aux_done) && b_ie)
         pend_b <= 1'b1;
      else if (b_data_wr || b_data_rd || b_cfg_wr || (a_data_rd && a_bidir))
         pend_b <= 1'b0;
   end

   assign irq = pend_a | pend_b;

   always_comb begin
      cfg_view = cpu_sel ? {b_ie, {PAD_W{1'b0}}, b_mode} : {a_ie, {PAD_W{1'b0}}, a_mode};
      cpu_rdata = cpu_ctl ? cfg_view : (cpu_sel ? b_rd : a_rd);
   end

   // R8
   a_rdy_ctrl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_mode == PM_CTRL && $past(a_mode == PM_CTRL)) |-> !a_rdy);

   // R9
   b_rdy_ctrl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_mode == PM_CTRL && $past(b_mode == PM_CTRL) && !a_bidir && !$past(a_bidir))
      |-> !b_rdy);

   // R4
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (a_ie || b_ie));
endmodule

// File: tb/tb_pio_dual_hs.sv
module tb_pio_dual_hs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel = 1'b0, cpu_ctl = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic [7:0] a_in = '0, b_in = '0, a_out, b_out;
   logic       a_oe, b_oe, a_rdy, b_rdy, irq;
   logic       a_stb_n = 1'b1, b_stb_n = 1'b1;
   int         checks = 0;
   int         errors = 0;
   logic [7:0] rv;

   always #2.5 clk = ~clk;

   pio_dual_hs dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_sel(cpu_sel), .cpu_ctl(cpu_ctl), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .a_stb_n(a_stb_n), .a_rdy(a_rdy), .b_in(b_in), .b_out(b_out),
      .b_oe(b_oe), .b_stb_n(b_stb_n), .b_rdy(b_rdy), .irq(irq)
   );

   // {mode[1:0], wdata[7:0], exp_out[7:0], exp_oe, exp_rdy}
   localparam int NVEC = 5;
   localparam logic [19:0] VEC [NVEC] = '{
      {2'd0, 8'h5A, 8'h5A, 1'b1, 1'b1},
      {2'd3, 8'hA5, 8'hA5, 1'b1, 1'b0},
      {2'd1, 8'h3C, 8'h3C, 1'b0, 1'b0},
      {2'd0, 8'hFF, 8'hFF, 1'b1, 1'b1},
      {2'd3, 8'h00, 8'h00, 1'b1, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cpu_w(input logic sel, input logic ctl, input logic [7:0] d);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_sel = sel; cpu_ctl = ctl; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_r(input logic sel, input logic ctl, output logic [7:0] d);
      @(negedge clk);
      cpu_rd = 1'b1; cpu_sel = sel; cpu_ctl = ctl;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 a_rdy", a_rdy, 0);
      chk("R1 b_rdy", b_rdy, 0);
      chk("R1 irq", irq, 0);
      chk("R1 a_oe", a_oe, 0);
      chk("R1 b_oe", b_oe, 0);
      cpu_r(0, 1, rv); chk("R1 ctl A", rv, 8'h01);
      cpu_r(1, 1, rv); chk("R1 ctl B", rv, 8'h01);

      // R2 mode 2 refused on port B, control readback
      cpu_w(1, 1, 8'h02);
      cpu_r(1, 1, rv); chk("R2 B refuses mode2", rv, 8'h01);
      cpu_w(0, 1, 8'h83);
      cpu_r(0, 1, rv); chk("R2 ctl A readback", rv, 8'h83);

      // R3 / R8 vector table on port A
      for (int i = 0; i < NVEC; i++) begin
         cpu_w(0, 1, {6'b0, VEC[i][19:18]});
         cpu_w(0, 0, VEC[i][17:10]);
         chk("R3/R8 table out", a_out, VEC[i][9:2]);
         chk("R3/R8 table oe", a_oe, VEC[i][1]);
         chk("R3/R8 table rdy", a_rdy, VEC[i][0]);
      end

      // R3 / R4 mode 0 with interrupt enabled
      cpu_w(0, 1, 8'h80);
      cpu_w(0, 0, 8'h11);
      chk("R3 rdy after write", a_rdy, 1);
      a_stb_n = 1'b0; wait_cyc(4);
      chk("R3 strobe clears rdy", a_rdy, 0);
      chk("R4 no irq before rise", irq, 0);
      a_stb_n = 1'b1; wait_cyc(4);
      chk("R4 irq on rise", irq, 1);
      cpu_w(0, 0, 8'h22);
      chk("R4 write clears irq", irq, 0);
      chk("R3 rdy rearmed", a_rdy, 1);

      // R4 mode 0 with interrupt disabled
      cpu_w(1, 1, 8'h00);
      cpu_w(1, 0, 8'h10);
      chk("R3 B rdy", b_rdy, 1);
      b_stb_n = 1'b0; wait_cyc(4);
      b_stb_n = 1'b1; wait_cyc(4);
      chk("R4 masked no irq", irq, 0);
      chk("R3 B rdy cleared", b_rdy, 0);

      // R5 mode 1 input with zero hold
      cpu_w(1, 1, 8'h81);
      chk("R5 oe low", b_oe, 0);
      cpu_r(1, 0, rv);
      chk("R5 read arms rdy", b_rdy, 1);
      b_in = 8'h77; b_stb_n = 1'b0; wait_cyc(4);
      chk("R5 strobe clears rdy", b_rdy, 0);
      b_stb_n = 1'b1; b_in = 8'hEE; wait_cyc(4);
      chk("R4 input irq", irq, 1);
      cpu_r(1, 0, rv);
      chk("R5 zero-hold data", rv, 8'h77);
      chk("R4 read clears irq", irq, 0);

      // R6 / R7 / R9 mode 2 on port A, B in control mode
      cpu_w(0, 1, 8'h82);
      cpu_w(1, 1, 8'h83);
      chk("R6 oe idle low", a_oe, 0);
      chk("R9 b_rdy idle", b_rdy, 0);
      cpu_w(0, 0, 8'h99);
      chk("R6 out data", a_out, 8'h99);
      chk("R6 rdy after write", a_rdy, 1);
      @(negedge clk); a_stb_n = 1'b0;
      #1 chk("R6 oe with strobe", a_oe, 1);
      wait_cyc(4);
      chk("R6 strobe clears rdy", a_rdy, 0);
      a_stb_n = 1'b1;
      #1 chk("R6 oe drops", a_oe, 0);
      wait_cyc(4);
      chk("R6 output irq", irq, 1);
      cpu_r(0, 0, rv);
      chk("R6 read clears irq", irq, 0);
      chk("R9 b_rdy follows A input", b_rdy, 1);
      a_in = 8'h42; b_stb_n = 1'b0; wait_cyc(4);
      chk("R7 b strobe clears b_rdy", b_rdy, 0);
      b_stb_n = 1'b1; a_in = 8'h00; wait_cyc(4);
      chk("R7 input irq via B enable", irq, 1);
      cpu_r(0, 0, rv);
      chk("R7 captured data", rv, 8'h42);
      chk("R7 read clears irq", irq, 0);
      cpu_w(1, 1, 8'h03);
      b_stb_n = 1'b0; wait_cyc(4);
      b_stb_n = 1'b1; wait_cyc(4);
      chk("R7 B enable off no irq", irq, 0);

      // R8 / R9 control mode
      cpu_w(0, 1, 8'h03);
      chk("R8 a_rdy low", a_rdy, 0);
      chk("R9 b_rdy low", b_rdy, 0);
      a_in = 8'h6B;
      cpu_r(0, 0, rv);
      chk("R8 live pins", rv, 8'h6B);
      cpu_r(1, 0, rv);
      chk("R9 b_rdy stays low", b_rdy, 0);
      a_stb_n = 1'b0; wait_cyc(4);
      a_stb_n = 1'b1; wait_cyc(4);
      chk("R8 strobe ignored rdy", a_rdy, 0);
      chk("R8 strobe ignored irq", irq, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule